// File: doc/BRIEF.md
# Serial Audio Link Power Sequencer

This block sits on the controller side of a serial audio link. The link carries 256-bit frames, and a frame-sync line marks the start of each frame. The sequencer takes the link down into a halted, low-power state and later brings it back up. Software asks for a powerdown by supplying a value for the codec's powerdown register. The sequencer waits for the next frame boundary and sends one frame that carries only that register write. From the end of that frame it holds its own sync and serial data outputs low.

While the link is halted the bit clock is stopped, so a free-running system clock times a minimum quiet period before any wake-up. Once that period has passed, a pending wake request is served in one of two ways. A warm wake drives a sync pulse with no bit clock present. A cold wake pulses an active-low codec reset. The `deepPd` input at wake time selects which form is used. Framing then restarts from bit 0. Playback and capture stay gated off until the codec reports that it is ready. The bit clock reaches the block as a one-cycle `bitTick` strobe from an upstream edge detector.

Top module: `acl_pwr_seq`

## Requirements
- R1: After reset the state code is 0, `audioEn` is 0 and `resetNOut` is 1. In states 0, 1 and 5 a bit counter advances on each `bitTick` through bits 0..255 of a frame, and `syncOut` is high exactly while the counter is below 16.
- R2: A `pdReq` pulse seen in state 0 is held pending, together with `pdData`. At the next end of frame (the tick at bit 255) the state becomes 1. A `pdReq` pulse in any other state is ignored.
- R3: In state 1, `sdataOut` sends 56 header bits MSB first, followed by zeros:
  - a 16-bit tag 0xE000, in which bit 15 marks the frame valid, bit 14 marks slot 1 valid, bit 13 marks slot 2 valid, and the other bits are 0;
  - a 20-bit slot 1 with bit 19 = 0 (write) and bits 18:12 = 0x26;
  - a 20-bit slot 2 with bits 19:4 = `pdData` OR 0x1000 (bit 12 is the powerdown bit) and bits 3:0 = 0.
- R4: At the end of the state-1 frame the state becomes 2. In states 2 and 3, `syncOut` and `sdataOut` are held at 0 and `audioEn` is 0.
- R5: State 2 lasts exactly `HOLD_CYC` clock cycles before the state becomes 3. A wake request made earlier is held and served only from state 3. Without a wake request, state 3 is kept.
- R6: A wake with `deepPd` = 0 enters state 4 for exactly `WARM_CYC` cycles. During those cycles `syncOut` is 1 and `resetNOut` is 1.
- R7: A wake with `deepPd` = 1 enters state 4 for exactly `RST_CYC` cycles. During those cycles `resetNOut` is 0 and `syncOut` is 0.
- R8: State 5 follows state 4, and framing restarts at bit 0. The state moves to 0 only after `sdataIn` is sampled high on the tick at bit 0, which is where the codec-ready bit sits.
- R9: `audioEn` is 1 only in state 0 with the ready flag set. The ready flag is updated on every bit-0 tick and cleared in state 2. In state 0, `sdataOut` equals `audioBit` AND `audioEn`.
- R10: `seqState` uses these codes:

  | Code | State |
  |---|---|
  | 0 | active |
  | 1 | powerdown frame |
  | 2 | halted |
  | 3 | hold-off done |
  | 4 | waking |
  | 5 | waiting for ready |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitTick | input | 1 | One-cycle strobe per bit-clock period |
| pdReq | input | 1 | Software powerdown request pulse |
| pdData | input | 16 | Powerdown register value to send |
| wakeReq | input | 1 | Software wake request pulse |
| deepPd | input | 1 | 1 selects a cold wake, 0 a warm wake |
| sdataIn | input | 1 | Serial input from the codec |
| audioBit | input | 1 | Outgoing audio bit from the upstream serializer |
| syncOut | output | 1 | Frame sync to the codec |
| sdataOut | output | 1 | Serial output to the codec |
| resetNOut | output | 1 | Active-low codec reset |
| audioEn | output | 1 | Playback and capture permitted |
| seqState | output | 3 | State code (R10) |

## Verification
The bench runs complete frames. In each frame it changes the value of the ready bit at bit 0, and it steers `audioBit` with a bit-index-dependent pattern, so that audio gating can be told apart from plain passthrough. The powerdown frame is compared bit for bit against two different register values, which separates fixed header fields from copied data. Two powerdown cycles are run. In the first, the wake request arrives early with a warm wake. In the second, the wake arrives late with a cold wake. This shows that the hold-off length does not depend on when the request arrives, and that the two wake forms drive disjoint lines for their own pulse widths. A powerdown request made while waiting for ready must leave no trace in the frames that follow.

// File: rtl/acl_pwr_pkg.sv
package acl_pwr_pkg;
  typedef enum logic [2:0] {
    ST_ACTIVE     = 3'd0,
    ST_PD_FRAME   = 3'd1,
    ST_HALTED     = 3'd2,
    ST_HOLD_DONE  = 3'd3,
    ST_WAKING     = 3'd4,
    ST_WAIT_READY = 3'd5
  } seq_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic runFrame;
    logic genPd;
    logic passAudio;
    logic warmPulse;
    logic coldRst;
    logic clrReady;
    logic latchPd;
  } seq_strobe_t;
endpackage

// File: rtl/acl_pwr_ctrl.sv
module acl_pwr_ctrl
  import acl_pwr_pkg::*;
#(
  parameter int HOLD_CYC = 10240,
  parameter int WARM_CYC = 125,
  parameter int RST_CYC  = 125
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pdReq,
  input  logic        wakeReq,
  input  logic        deepPd,
  input  logic        frameEnd,
  input  logic        codecReady,
  output seq_state_e  stateQ,
  output seq_strobe_t strobe
);
  localparam int CNT_MAX = (HOLD_CYC > WARM_CYC) ?
                           ((HOLD_CYC > RST_CYC) ? HOLD_CYC : RST_CYC) :
                           ((WARM_CYC > RST_CYC) ? WARM_CYC : RST_CYC);
  localparam int CW = $clog2(CNT_MAX + 1);

  logic          pdPend;
  logic          wakePend;
  logic          coldMode;
  logic [CW-1:0] cnt;
  logic [CW-1:0] wakeLast;

  assign wakeLast = coldMode ? CW'(RST_CYC - 1) : CW'(WARM_CYC - 1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= ST_ACTIVE;
      pdPend   <= 1'b0;
      wakePend <= 1'b0;
      coldMode <= 1'b0;
      cnt      <= '0;
    end else begin
      if (wakeReq && (stateQ == ST_HALTED || stateQ == ST_HOLD_DONE))
        wakePend <= 1'b1;
      case (stateQ)
        ST_ACTIVE: begin
          if (pdReq) pdPend <= 1'b1;
          if (frameEnd && pdPend) begin
            stateQ <= ST_PD_FRAME;
            pdPend <= 1'b0;
          end
        end
        ST_PD_FRAME: begin
          if (frameEnd) begin
            stateQ <= ST_HALTED;
            cnt    <= '0;
          end
        end
        ST_HALTED: begin
          if (cnt == CW'(HOLD_CYC - 1)) stateQ <= ST_HOLD_DONE;
          else cnt <= cnt + 1'b1;
        end
        ST_HOLD_DONE: begin
          if (wakePend) begin
            stateQ   <= ST_WAKING;
            wakePend <= 1'b0;
            coldMode <= deepPd;
            cnt      <= '0;
          end
        end
        ST_WAKING: begin
          if (cnt == wakeLast) stateQ <= ST_WAIT_READY;
          else cnt <= cnt + 1'b1;
        end
        ST_WAIT_READY: begin
          if (codecReady) stateQ <= ST_ACTIVE;
        end
        default: stateQ <= ST_ACTIVE;
      endcase
    end
  end

  always_comb begin
    strobe.runFrame  = (stateQ == ST_ACTIVE) || (stateQ == ST_PD_FRAME) ||
                       (stateQ == ST_WAIT_READY);
    strobe.genPd     = (stateQ == ST_PD_FRAME);
    strobe.passAudio = (stateQ == ST_ACTIVE);
    strobe.warmPulse = (stateQ == ST_WAKING) && !coldMode;
    strobe.coldRst   = (stateQ == ST_WAKING) && coldMode;
    strobe.clrReady  = (stateQ == ST_HALTED);
    strobe.latchPd   = (stateQ == ST_ACTIVE) && pdReq;
  end
endmodule

// File: rtl/acl_pwr_dp.sv
module acl_pwr_dp
  import acl_pwr_pkg::*;
#(
  parameter int         SLOT0_BITS = 16,
  parameter int         SLOT_BITS  = 20,
  parameter int         NUM_SLOTS  = 12,
  parameter logic [6:0] PD_INDEX   = 7'h26,
  parameter int         PD_BIT     = 12
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        bitTick,
  input  logic        sdataIn,
  input  logic        audioBit,
  input  logic [15:0] pdData,
  input  seq_strobe_t strobe,
  output logic        frameEnd,
  output logic        codecReady,
  output logic        syncOut,
  output logic        sdataOut,
  output logic        resetNOut,
  output logic        audioEn
);
  localparam int FRAME_BITS = SLOT0_BITS + NUM_SLOTS * SLOT_BITS;
  localparam int BW         = $clog2(FRAME_BITS);
  localparam int HEAD_BITS  = SLOT0_BITS + 2 * SLOT_BITS;

  logic [BW-1:0]        bitCnt;
  logic [15:0]          pdWord;
  logic [HEAD_BITS-1:0] frameHead;
  logic                 pdBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt     <= '0;
      codecReady <= 1'b0;
      pdWord     <= '0;
    end else begin
      if (!strobe.runFrame) bitCnt <= '0;
      else if (bitTick)
        bitCnt <= (bitCnt == BW'(FRAME_BITS - 1)) ? '0 : bitCnt + 1'b1;
      if (strobe.clrReady) codecReady <= 1'b0;
      else if (strobe.runFrame && bitTick && bitCnt == '0) codecReady <= sdataIn;
      if (strobe.latchPd) pdWord <= pdData;
    end
  end

  // tag: frame valid, slot 1 valid, slot 2 valid; slot 1 write command; slot 2 data
  assign frameHead = {3'b111, {(SLOT0_BITS - 3){1'b0}},
                      1'b0, PD_INDEX, {(SLOT_BITS - 8){1'b0}},
                      pdWord | (16'd1 << PD_BIT), {(SLOT_BITS - 16){1'b0}}};

  always_comb begin
    pdBit = 1'b0;
    for (int i = 0; i < HEAD_BITS; i++)
      if (bitCnt == BW'(i)) pdBit = frameHead[HEAD_BITS - 1 - i];
  end

  assign frameEnd  = strobe.runFrame && bitTick && (bitCnt == BW'(FRAME_BITS - 1));
  assign audioEn   = strobe.passAudio && codecReady;
  assign syncOut   = strobe.warmPulse || (strobe.runFrame && (bitCnt < BW'(SLOT0_BITS)));
  assign sdataOut  = strobe.genPd ? pdBit : (audioEn && audioBit);
  assign resetNOut = !strobe.coldRst;
endmodule

// File: rtl/acl_pwr_seq.sv
module acl_pwr_seq
  import acl_pwr_pkg::*;
#(
  parameter int SLOT0_BITS  = 16,
  parameter int SLOT_BITS   = 20,
  parameter int NUM_SLOTS   = 12,
  parameter int CLK_PER_BIT = 10,
  parameter int HOLD_FRAMES = 4,
  parameter int HOLD_CYC    = HOLD_FRAMES * (SLOT0_BITS + NUM_SLOTS * SLOT_BITS) * CLK_PER_BIT,
  parameter int WARM_CYC    = 125,
  parameter int RST_CYC     = 125
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        bitTick,
  input  logic        pdReq,
  input  logic [15:0] pdData,
  input  logic        wakeReq,
  input  logic        deepPd,
  input  logic        sdataIn,
  input  logic        audioBit,
  output logic        syncOut,
  output logic        sdataOut,
  output logic        resetNOut,
  output logic        audioEn,
  output logic [2:0]  seqState
);
  seq_state_e  stateQ;
  seq_strobe_t strobe;
  logic        frameEnd;
  logic        codecReady;

  acl_pwr_ctrl #(
    .HOLD_CYC(HOLD_CYC), .WARM_CYC(WARM_CYC), .RST_CYC(RST_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .pdReq(pdReq), .wakeReq(wakeReq), .deepPd(deepPd),
    .frameEnd(frameEnd), .codecReady(codecReady), .stateQ(stateQ), .strobe(strobe)
  );

  acl_pwr_dp #(
    .SLOT0_BITS(SLOT0_BITS), .SLOT_BITS(SLOT_BITS), .NUM_SLOTS(NUM_SLOTS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .sdataIn(sdataIn), .audioBit(audioBit),
    .pdData(pdData), .strobe(strobe), .frameEnd(frameEnd), .codecReady(codecReady),
    .syncOut(syncOut), .sdataOut(sdataOut), .resetNOut(resetNOut), .audioEn(audioEn)
  );

  assign seqState = stateQ;
endmodule

// File: rtl/acl_pwr_seq_chk.sv
module acl_pwr_seq_chk #(
  parameter int HOLD_CYC = 10240
) (
  input logic       clk,
  input logic       rstN,
  input logic       syncOut,
  input logic       sdataOut,
  input logic       resetNOut,
  input logic       audioEn,
  input logic [2:0] seqState
);
  localparam int QW = $clog2(HOLD_CYC + 1);
  logic [QW-1:0] quietCnt;

  always_ff @(posedge clk) begin
    if (!rstN) quietCnt <= '0;
    else if (seqState == 3'd2) begin
      if (quietCnt != QW'(HOLD_CYC)) quietCnt <= quietCnt + 1'b1;
    end else if (seqState != 3'd3) quietCnt <= '0;
  end

  a_r2_pd_from_active: assert property (@(posedge clk) disable iff (!rstN)
    seqState == 3'd1 |-> ($past(seqState) == 3'd0 || $past(seqState) == 3'd1));
  a_r4_halt_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (seqState == 3'd2 || seqState == 3'd3) |-> (!syncOut && !sdataOut && !audioEn));
  a_r5_holdoff_min: assert property (@(posedge clk) disable iff (!rstN)
    seqState == 3'd3 |-> quietCnt >= QW'(HOLD_CYC));
  a_r6_warm_no_reset: assert property (@(posedge clk) disable iff (!rstN)
    (seqState == 3'd4 && syncOut) |-> resetNOut);
  a_r7_cold_no_sync: assert property (@(posedge clk) disable iff (!rstN)
    !resetNOut |-> !syncOut);
  a_r9_gate_active: assert property (@(posedge clk) disable iff (!rstN)
    audioEn |-> seqState == 3'd0);
endmodule

bind acl_pwr_seq acl_pwr_seq_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (
  .clk(clk), .rstN(rstN), .syncOut(syncOut), .sdataOut(sdataOut),
  .resetNOut(resetNOut), .audioEn(audioEn), .seqState(seqState)
);

// File: tb/acl_pwr_seq_bench.sv
module acl_pwr_seq_bench;
  localparam int HOLD = 40;
  localparam int WARM = 5;
  localparam int RSTW = 7;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN = 1'b0, bitTick = 1'b0, pdReq = 1'b0, wakeReq = 1'b0, deepPd = 1'b0;
  logic sdataIn = 1'b0, audioBit = 1'b0;
  logic [15:0] pdData = '0;
  logic syncOut, sdataOut, resetNOut, audioEn;
  logic [2:0] seqState;

  int nRun = 0, nFail = 0, tbBit = 0;
  bit done = 0;

  acl_pwr_seq #(.HOLD_CYC(HOLD), .WARM_CYC(WARM), .RST_CYC(RSTW)) u_acl_pwr_seq (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .pdReq(pdReq), .pdData(pdData),
    .wakeReq(wakeReq), .deepPd(deepPd), .sdataIn(sdataIn), .audioBit(audioBit),
    .syncOut(syncOut), .sdataOut(sdataOut), .resetNOut(resetNOut),
    .audioEn(audioEn), .seqState(seqState));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic expPdBit(input int b, input logic [15:0] d);
    logic [55:0] head;
    head = {16'hE000, 20'h26000, d | 16'h1000, 4'h0};
    return (b < 56) ? head[55 - b] : 1'b0;
  endfunction

  // one bit period: tick high for one clock, low for one
  task automatic stepBit(input logic din);
    sdataIn = din;
    bitTick = 1'b1;
    @(negedge clk);
    bitTick = 1'b0;
    @(negedge clk);
    tbBit = (tbBit + 1) % 256;
  endtask

  // mode 0: audio frame, mode 1: powerdown frame with data d
  task automatic runFrame(input logic rdy, input int mode, input logic expAud,
                          input logic [15:0] d);
    int syncErr = 0, datErr = 0, audErr = 0;
    for (int b = 0; b < 256; b++) begin
      audioBit = tbBit[0] ^ tbBit[2];
      #1;
      if (syncOut !== (tbBit < 16)) syncErr++;
      if (mode == 1) begin
        if (sdataOut !== expPdBit(tbBit, d) || seqState !== 3'd1 || audioEn !== 1'b0)
          datErr++;
      end else if (tbBit > 0) begin
        if (audioEn !== expAud || sdataOut !== (expAud & audioBit)) audErr++;
      end
      stepBit((b == 0) ? rdy : 1'b0);
    end
    chk(syncErr == 0, "R1 sync framing", syncErr, 0);
    if (mode == 1) chk(datErr == 0, "R3 powerdown frame bits", datErr, 0);
    else chk(audErr == 0, "R9 audio gating", audErr, 0);
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1;
    @(negedge clk);
    sig = 1'b0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    nFail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    int haltN, wakeN, quietErr, lineErr;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 / R10 reset state
    chk(seqState == 3'd0, "R10 reset state code", seqState, 0);
    chk(audioEn == 1'b0 && resetNOut == 1'b1, "R1 reset outputs", {audioEn, resetNOut}, 1);
    chk(syncOut == 1'b1, "R1 sync at bit 0", syncOut, 1);

    runFrame(1'b1, 0, 1'b1, 16'h0);
    runFrame(1'b0, 0, 1'b0, 16'h0);     // R9 ready drops
    runFrame(1'b1, 0, 1'b1, 16'h0);

    // first powerdown, warm wake
    pdData = 16'h0300;
    pulse(pdReq);
    runFrame(1'b1, 0, 1'b1, 16'h0);
    chk(seqState == 3'd1, "R2 powerdown frame follows boundary", seqState, 1);
    runFrame(1'b1, 1, 1'b0, 16'h0300);
    chk(seqState == 3'd2, "R4 halted after frame", seqState, 2);

    deepPd = 1'b0;
    wakeReq = 1'b1;
    haltN = 0; wakeN = 0; quietErr = 0; lineErr = 0;
    for (int g = 0; g < 2000 && seqState != 3'd5; g++) begin
      if (seqState == 3'd2) haltN++;
      if (seqState == 3'd2 || seqState == 3'd3)
        if (syncOut || sdataOut || audioEn) quietErr++;
      if (seqState == 3'd4) begin
        wakeN++;
        if (!syncOut || !resetNOut) lineErr++;
      end
      @(negedge clk);
      wakeReq = 1'b0;
    end
    #1;
    chk(quietErr == 0, "R4 lines low while halted", quietErr, 0);
    chk(haltN == HOLD - 1, "R5 early wake deferred to hold-off", haltN, HOLD - 1);
    chk(wakeN == WARM, "R6 warm pulse width", wakeN, WARM);
    chk(lineErr == 0, "R6 warm pulse lines", lineErr, 0);
    chk(seqState == 3'd5, "R8 wait for ready", seqState, 5);
    tbBit = 0;

    pulse(pdReq);                      // ignored outside active (R2)
    runFrame(1'b0, 0, 1'b0, 16'h0);
    chk(seqState == 3'd5, "R8 no ready keeps waiting", seqState, 5);
    runFrame(1'b1, 0, 1'b1, 16'h0);
    chk(seqState == 3'd0, "R8 ready returns active", seqState, 0);
    runFrame(1'b1, 0, 1'b1, 16'h0);
    chk(seqState == 3'd0, "R2 request outside active ignored", seqState, 0);

    // second powerdown, cold wake, late request
    deepPd = 1'b1;
    pdData = 16'h0000;
    pulse(pdReq);
    runFrame(1'b1, 0, 1'b1, 16'h0);
    runFrame(1'b1, 1, 1'b0, 16'h0000);
    repeat (HOLD + 20) @(negedge clk);
    #1;
    chk(seqState == 3'd3, "R5 hold-off done waits for request", seqState, 3);
    chk(syncOut == 1'b0 && sdataOut == 1'b0, "R4 quiet in hold-off done",
        {syncOut, sdataOut}, 0);
    wakeReq = 1'b1;
    wakeN = 0; lineErr = 0;
    for (int g = 0; g < 2000 && seqState != 3'd5; g++) begin
      if (seqState == 3'd4) begin
        wakeN++;
        if (resetNOut || syncOut) lineErr++;
      end
      @(negedge clk);
      wakeReq = 1'b0;
    end
    #1;
    chk(wakeN == RSTW, "R7 cold reset width", wakeN, RSTW);
    chk(lineErr == 0, "R7 cold reset lines", lineErr, 0);
    chk(resetNOut == 1'b1, "R7 reset released", resetNOut, 1);
    tbBit = 0;
    runFrame(1'b1, 0, 1'b1, 16'h0);
    chk(seqState == 3'd0, "R8 active after cold wake", seqState, 0);
    summary();
  end
endmodule